// File: doc/BRIEF.md
# Sleep Mode and Wake-up Controller

This block is the power manager beside a small 8-bit processor core. When the core issues a sleep request, the block checks the sleep-enable bit and a 3-bit mode code. If both allow sleep, it removes the clock enables for that mode. The modes are idle, ADC noise reduction, power-down and power-save. While the core sleeps, the block watches the wake sources. It accepts only the sources that the current mode permits, that are individually enabled, and that the global interrupt flag allows. A reset-class event always wakes the core.

When a wake is accepted from one of the two deepest modes, the oscillator is started first. The CPU clock stays gated for a programmable start-up time of 0, 16 or 64 cycles. From idle and ADC noise reduction, the core resumes on the next cycle. The CPU clock is restored in a single resume cycle, and a wake strobe is raised during that cycle. On entry to idle or ADC noise reduction with the ADC enabled, the block issues a one-cycle conversion-start strobe.

The controller is a four-state machine:
- `ST_RUN`: the core is active.
- `ST_DOZE`: the core is asleep and the clock gates of its mode apply.
- `ST_WARM`: the oscillator is settling and the start-up count is running.
- `ST_RESUME`: one cycle in which the clocks return and the wake strobe is raised.

The transitions are:
- enter: `ST_RUN` to `ST_DOZE`.
- shallow-wake: `ST_DOZE` to `ST_RESUME`.
- deep-wake: `ST_DOZE` to `ST_WARM`.
- settled: `ST_WARM` to `ST_RESUME`.
- resume: `ST_RESUME` to `ST_RUN`.

Top module: `sleep_ctrl`

## Requirements
- R1: From the active state, a sleep request with `sleep_en`=1 and `mode_sel` in 000..011 gates the CPU clock from the next cycle. With `sleep_en`=0, or with `mode_sel[2]`=1 (codes 100..111 are reserved), the request is ignored and every clock enable stays 1.
- R2: The clock enables are listed in the order {cpu, io, flash, adc, osc, tmr2}:
  - After reset, and whenever the core runs, all are 1.
  - In idle (000): 011111.
  - In ADC noise reduction (001): 000111.
  - In power-down (010): 000000.
  - In power-save (011): 00000 followed by the value of `async_t2`.
- R3: Idle accepts every wake source: all six event lines and both external level lines.
- R4: ADC noise reduction accepts the external lines and event bits 0..4. The event bits are: bit 0 two-wire address match, bit 1 timer-2 overflow, bit 2 timer-2 compare, bit 3 ADC done, bit 4 EEPROM/self-program ready. Bit 5 (any other internal interrupt) is refused.
- R5: Power-down accepts only the external level lines and event bit 0.
- R6: Power-save accepts what power-down accepts. It also accepts event bits 1 and 2, but only when `async_t2`=1.
- R7: An interrupt source wakes the core only if its enable bit and `gie` are both 1. `rst_evt` wakes the core from any sleep mode, regardless of the enables.
- R8: An external level line counts as a wake source only after it has been high for `LVL_HOLD` (default 4) consecutive cycles. A shorter pulse is ignored.
- R9: `adc_start` pulses for one cycle, in the first sleep cycle, when idle or ADC noise reduction is entered with `adc_en`=1. It stays low otherwise.
- R10: A wake from power-down or power-save keeps the CPU clock gated, with `osc_en`=1, for N cycles before the resume cycle. `sut_sel` selects N: 00 gives 0, 01 gives 16, 1x gives 64. The total latency from the accepting edge is therefore N+1 cycles. A wake from idle or ADC noise reduction resumes after 1 cycle.
- R11: `wake_pulse` is high for exactly one cycle: the first cycle in which `cpu_clk_en` is 1 again. In that cycle all clock enables are 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running controller clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sleep_req | input | 1 | One-cycle sleep request from the core |
| sleep_en | input | 1 | Sleep permitted |
| mode_sel | input | 3 | Sleep mode code |
| adc_en | input | 1 | ADC enabled |
| async_t2 | input | 1 | Timer 2 runs from its own clock |
| gie | input | 1 | Global interrupt flag |
| evt_pend | input | 6 | Pending event lines (bit map in R4) |
| evt_en | input | 6 | Per-event enable bits |
| ext_lvl | input | NUM_EXT | External level interrupt lines |
| ext_en | input | NUM_EXT | Per-line enable bits |
| rst_evt | input | 1 | Reset-class wake event |
| sut_sel | input | 2 | Start-up delay select |
| cpu_clk_en | output | 1 | CPU clock enable |
| io_clk_en | output | 1 | I/O clock enable |
| flash_clk_en | output | 1 | Flash clock enable |
| adc_clk_en | output | 1 | ADC clock enable |
| osc_en | output | 1 | Main oscillator enable |
| tmr2_clk_en | output | 1 | Timer 2 clock enable |
| adc_start | output | 1 | ADC conversion-start strobe |
| wake_pulse | output | 1 | One-cycle wake indication |

## Verification
The bench sweeps every legal mode, both timer-clock settings and each of the eight wake sources. It predicts from the mode table whether each source should wake the core, and the exact latency in cycles. A design with a wrong mode mask either wakes from a refused source, such as timer 2 in power-save without the asynchronous clock, or stays asleep on a permitted one. A start-up counter that is off by one shifts the measured deep-mode latency away from N+1. A level filter that counts one cycle short accepts a pulse of `LVL_HOLD`-1 cycles. The bench also sends requests with sleep disabled or a reserved mode code, and wakes with `gie` or the source enable cleared. A design that ignores those qualifiers goes to sleep, or wakes, when it should not.

// File: rtl/slp_pkg.sv
package slp_pkg;

    localparam logic [2:0] MD_IDLE  = 3'd0;
    localparam logic [2:0] MD_ADCNR = 3'd1;
    localparam logic [2:0] MD_PDOWN = 3'd2;
    localparam logic [2:0] MD_PSAVE = 3'd3;

    localparam int NUM_EVT  = 6;
    localparam int EV_TWI   = 0;
    localparam int EV_T2OVF = 1;
    localparam int EV_T2CMP = 2;
    localparam int EV_ADC   = 3;
    localparam int EV_NVM   = 4;
    localparam int EV_MISC  = 5;

    typedef enum logic [1:0] {
        ST_RUN    = 2'd0,
        ST_DOZE   = 2'd1,
        ST_WARM   = 2'd2,
        ST_RESUME = 2'd3
    } pm_state_t;

    typedef struct packed {
        logic cpu;
        logic io;
        logic flash;
        logic adc;
        logic osc;
        logic tmr;
    } clk_gate_t;

    // Event lines each sleep mode lets through.
    function automatic logic [NUM_EVT-1:0] evt_allow(input logic [2:0] mode,
                                                     input logic       async_t2);
        logic [NUM_EVT-1:0] m;
        m = '0;
        case (mode)
            MD_IDLE:  m = '1;
            MD_ADCNR: begin
                m = '1;
                m[EV_MISC] = 1'b0;
            end
            MD_PDOWN: m[EV_TWI] = 1'b1;
            MD_PSAVE: begin
                m[EV_TWI]   = 1'b1;
                m[EV_T2OVF] = async_t2;
                m[EV_T2CMP] = async_t2;
            end
            default:  m = '0;
        endcase
        return m;
    endfunction

    // Clock gates that hold while dozing in a given mode.
    function automatic clk_gate_t doze_gates(input logic [2:0] mode,
                                             input logic       async_t2);
        clk_gate_t g;
        g = '0;
        case (mode)
            MD_IDLE:  g = '{cpu: 1'b0, io: 1'b1, flash: 1'b1, adc: 1'b1, osc: 1'b1, tmr: 1'b1};
            MD_ADCNR: g = '{cpu: 1'b0, io: 1'b0, flash: 1'b0, adc: 1'b1, osc: 1'b1, tmr: 1'b1};
            MD_PSAVE: g.tmr = async_t2;
            default:  g = '0;
        endcase
        return g;
    endfunction

    function automatic logic is_deep(input logic [2:0] mode);
        return (mode == MD_PDOWN) || (mode == MD_PSAVE);
    endfunction

endpackage

// File: rtl/pm_level_filter.sv
module pm_level_filter #(
    parameter int HOLD = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic lvl_in,
    output logic qual
);
    localparam int CW = $clog2(HOLD + 1);
    localparam logic [CW-1:0] LIM = CW'(HOLD);

    logic [CW-1:0] run_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            run_q <= '0;
        end else if (!lvl_in) begin
            run_q <= '0;
        end else if (run_q != LIM) begin
            run_q <= run_q + 1'b1;
        end
    end

    assign qual = (run_q == LIM);

    AST_LVL_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        qual |-> $past(lvl_in)); // R8

endmodule

// File: rtl/pm_startup_timer.sv
module pm_startup_timer #(
    parameter int SHORT_LEN = 16,
    parameter int LONG_LEN  = 64
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       arm,
    input  logic [1:0] sel,
    output logic       zero_len,
    output logic       done
);
    localparam int CW = $clog2(LONG_LEN + 1);

    logic [CW-1:0] cnt_q;
    logic [CW-1:0] lim_q;
    logic          busy_q;
    logic [CW-1:0] sel_len;

    always_comb begin
        unique case (sel)
            2'b00:   sel_len = '0;
            2'b01:   sel_len = CW'(SHORT_LEN);
            default: sel_len = CW'(LONG_LEN);
        endcase
    end

    assign zero_len = (sel_len == '0);
    assign done     = busy_q && (cnt_q == lim_q - 1'b1);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q  <= '0;
            lim_q  <= '0;
            busy_q <= 1'b0;
        end else if (arm) begin
            cnt_q  <= '0;
            lim_q  <= sel_len;
            busy_q <= 1'b1;
        end else if (busy_q) begin
            cnt_q <= cnt_q + 1'b1;
            if (done) busy_q <= 1'b0;
        end
    end

    AST_WARM_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_q && $past(busy_q) && !$past(arm)) |-> (cnt_q == $past(cnt_q) + 1'b1)); // R10

endmodule

// File: rtl/sleep_ctrl.sv
module sleep_ctrl
    import slp_pkg::*;
#(
    parameter int LVL_HOLD  = 4,
    parameter int SUT_SHORT = 16,
    parameter int SUT_LONG  = 64,
    parameter int NUM_EXT   = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               sleep_req,
    input  logic               sleep_en,
    input  logic [2:0]         mode_sel,
    input  logic               adc_en,
    input  logic               async_t2,
    input  logic               gie,
    input  logic [NUM_EVT-1:0] evt_pend,
    input  logic [NUM_EVT-1:0] evt_en,
    input  logic [NUM_EXT-1:0] ext_lvl,
    input  logic [NUM_EXT-1:0] ext_en,
    input  logic               rst_evt,
    input  logic [1:0]         sut_sel,
    output logic               cpu_clk_en,
    output logic               io_clk_en,
    output logic               flash_clk_en,
    output logic               adc_clk_en,
    output logic               osc_en,
    output logic               tmr2_clk_en,
    output logic               adc_start,
    output logic               wake_pulse
);

    pm_state_t     state_q, state_d;
    logic [2:0]    mode_q;
    logic          adc_start_q;
    logic [NUM_EXT-1:0] ext_qual;
    logic          enter, wake_hit, arm, zero_len, warm_done, evt_hit, ext_hit;
    clk_gate_t     gates;

    for (genvar i = 0; i < NUM_EXT; i++) begin : g_ext
        pm_level_filter #(.HOLD(LVL_HOLD)) u_filt (
            .clk    (clk),
            .rst_n  (rst_n),
            .lvl_in (ext_lvl[i]),
            .qual   (ext_qual[i])
        );
    end

    pm_startup_timer #(.SHORT_LEN(SUT_SHORT), .LONG_LEN(SUT_LONG)) u_sut (
        .clk      (clk),
        .rst_n    (rst_n),
        .arm      (arm),
        .sel      (sut_sel),
        .zero_len (zero_len),
        .done     (warm_done)
    );

    assign enter    = sleep_req && sleep_en && !mode_sel[2];
    assign evt_hit  = |(evt_pend & evt_en & evt_allow(mode_q, async_t2));
    assign ext_hit  = |(ext_qual & ext_en);
    assign wake_hit = rst_evt || (gie && (evt_hit || ext_hit));
    assign arm      = (state_q == ST_DOZE) && wake_hit && is_deep(mode_q) && !zero_len;

    // Next-state logic.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_RUN:    if (enter) state_d = ST_DOZE;
            ST_DOZE:   if (wake_hit) state_d = arm ? ST_WARM : ST_RESUME;
            ST_WARM:   if (warm_done) state_d = ST_RESUME;
            ST_RESUME: state_d = ST_RUN;
        endcase
    end

    // State register, latched mode and ADC strobe.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q     <= ST_RUN;
            mode_q      <= MD_IDLE;
            adc_start_q <= 1'b0;
        end else begin
            state_q     <= state_d;
            adc_start_q <= (state_q == ST_RUN) && enter && adc_en && !mode_sel[1];
            if ((state_q == ST_RUN) && enter) mode_q <= mode_sel;
        end
    end

    // Output decode.
    always_comb begin
        gates = '1;
        unique case (state_q)
            ST_RUN, ST_RESUME: gates = '1;
            ST_DOZE:           gates = doze_gates(mode_q, async_t2);
            ST_WARM: begin
                gates     = '0;
                gates.osc = 1'b1;
                gates.tmr = (mode_q == MD_PSAVE) && async_t2;
            end
        endcase
    end

    assign cpu_clk_en   = gates.cpu;
    assign io_clk_en    = gates.io;
    assign flash_clk_en = gates.flash;
    assign adc_clk_en   = gates.adc;
    assign osc_en       = gates.osc;
    assign tmr2_clk_en  = gates.tmr;
    assign adc_start    = adc_start_q;
    assign wake_pulse   = (state_q == ST_RESUME);

    AST_ENTRY_QUALIFIED: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(cpu_clk_en) |-> $past(sleep_req && sleep_en && !mode_sel[2])); // R1
    AST_ADC_START_CTX: assert property (@(posedge clk) disable iff (!rst_n)
        adc_start |-> $past(adc_en && mode_sel[2:1] == 2'b00)); // R9
    AST_WAKE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        wake_pulse |=> !wake_pulse); // R11
    AST_WAKE_AFTER_GATE: assert property (@(posedge clk) disable iff (!rst_n)
        wake_pulse |-> $past(!cpu_clk_en)); // R11

endmodule

// File: tb/tb_sleep_ctrl.sv
module tb_sleep_ctrl;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       sleep_req = 0, sleep_en = 0, adc_en = 0, async_t2 = 0, gie = 0, rst_evt = 0;
    logic [2:0] mode_sel = 0;
    logic [5:0] evt_pend = 0, evt_en = 0;
    logic [1:0] ext_lvl = 0, ext_en = 0, sut_sel = 0;
    logic cpu_clk_en, io_clk_en, flash_clk_en, adc_clk_en, osc_en, tmr2_clk_en, adc_start, wake_pulse;

    int checks = 0;
    int errs = 0;
    bit done = 0;
    localparam int HOLD = 4;

    always #4 clk = ~clk;

    sleep_ctrl dut (
        .clk(clk), .rst_n(rst_n), .sleep_req(sleep_req), .sleep_en(sleep_en),
        .mode_sel(mode_sel), .adc_en(adc_en), .async_t2(async_t2), .gie(gie),
        .evt_pend(evt_pend), .evt_en(evt_en), .ext_lvl(ext_lvl), .ext_en(ext_en),
        .rst_evt(rst_evt), .sut_sel(sut_sel), .cpu_clk_en(cpu_clk_en),
        .io_clk_en(io_clk_en), .flash_clk_en(flash_clk_en), .adc_clk_en(adc_clk_en),
        .osc_en(osc_en), .tmr2_clk_en(tmr2_clk_en), .adc_start(adc_start),
        .wake_pulse(wake_pulse)
    );

    function automatic int gates();
        return {cpu_clk_en, io_clk_en, flash_clk_en, adc_clk_en, osc_en, tmr2_clk_en};
    endfunction

    task automatic chk(string req, string what, int act, int exp);
        checks++;
        if (act != exp) begin
            errs++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    function automatic int exp_gates(int mode, int as);
        case (mode)
            0: return 6'b011111;
            1: return 6'b000111;
            2: return 6'b000000;
            default: return as;
        endcase
    endfunction

    function automatic bit allowed(int mode, int as, int src);
        if (src >= 6) return 1;
        case (mode)
            0: return 1;
            1: return src <= 4;
            2: return src == 0;
            default: return (src == 0) || (as == 1 && (src == 1 || src == 2));
        endcase
    endfunction

    function automatic int sut_len(int s);
        return (s == 0) ? 0 : (s == 1) ? 16 : 64;
    endfunction

    function automatic string mreq(int mode);
        case (mode)
            0: return "R3";
            1: return "R4";
            2: return "R5";
            default: return "R6";
        endcase
    endfunction

    // Wait up to lim sampled cycles for wake_pulse; 0 when it never came.
    task automatic wait_wake(int lim, output int k);
        k = 0;
        for (int i = 1; i <= lim; i++) begin
            @(negedge clk);
            if (wake_pulse) begin
                k = i;
                break;
            end
        end
    endtask

    task automatic go_sleep(int mode);
        sleep_en = 1; mode_sel = 3'(mode); sleep_req = 1;
        @(negedge clk);
        sleep_req = 0;
    endtask

    task automatic run(int mode, int as, int src, int sut, bit ae, bit g, bit en);
        int k, n, lat;
        bit deep, expw;
        async_t2 = as; sut_sel = 2'(sut); adc_en = ae; gie = g;
        evt_en = 0; ext_en = 0;
        go_sleep(mode);
        chk("R2", $sformatf("gates mode=%0d as=%0d", mode, as), gates(), exp_gates(mode, as));
        chk("R9", $sformatf("adc_start mode=%0d adc_en=%0d", mode, ae), adc_start, (ae && mode < 2) ? 1 : 0);
        deep = (mode >= 2);
        n = deep ? sut_len(sut) : 0;
        expw = en && g && allowed(mode, as, src);
        if (src < 6) begin evt_pend[src] = 1; evt_en[src] = en; end
        else begin ext_lvl[src-6] = 1; ext_en[src-6] = en; end
        wait_wake(100, k);
        lat = expw ? ((src >= 6 ? HOLD : 0) + 1 + n) : 0;
        chk(src >= 6 ? "R8" : (en && g) ? mreq(mode) : "R7",
            $sformatf("wake latency mode=%0d as=%0d src=%0d sut=%0d", mode, as, src, sut), k, lat);
        evt_pend = 0; ext_lvl = 0;
        if (k == 0) begin
            chk("R1", "still gated before reset wake", cpu_clk_en, 0);
            rst_evt = 1;
            wait_wake(100, k);
            rst_evt = 0;
            chk("R7", $sformatf("reset wake mode=%0d sut=%0d", mode, sut), k, 1 + n);
        end
        if (k != 0) begin
            chk("R11", "all clocks back on wake", gates(), 6'b111111);
            @(negedge clk);
            chk("R11", "wake pulse single", wake_pulse, 0);
            chk("R10", $sformatf("osc on in run mode=%0d", mode), osc_en, 1);
        end
        repeat (2) @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++; errs++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", errs, checks);
            $finish;
        end
    end

    initial begin
        int k;
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        chk("R2", "reset gates", gates(), 6'b111111);
        chk("R11", "reset wake_pulse", wake_pulse, 0);
        chk("R9", "reset adc_start", adc_start, 0);

        // R1: disabled sleep and reserved codes are ignored
        sleep_en = 0; mode_sel = 0; sleep_req = 1;
        @(negedge clk); sleep_req = 0;
        chk("R1", "sleep_en=0 ignored", gates(), 6'b111111);
        for (int m = 4; m < 8; m++) begin
            sleep_en = 1; mode_sel = 3'(m); adc_en = 1; sleep_req = 1;
            @(negedge clk); sleep_req = 0;
            chk("R1", $sformatf("reserved mode %0d ignored", m), gates(), 6'b111111);
            chk("R9", "no adc_start on reserved", adc_start, 0);
        end

        // Main sweep over modes, timer clock select and sources
        for (int m = 0; m < 4; m++)
            for (int a = 0; a < 2; a++)
                for (int s = 0; s < 8; s++)
                    run(m, a, s, (s + m) % 3, s[0] ^ a[0], 1, 1);

        // R7: gie or source enable cleared
        run(0, 0, 5, 0, 0, 0, 1);
        run(0, 0, 3, 0, 0, 1, 0);
        run(2, 1, 6, 1, 0, 0, 1);
        run(3, 1, 1, 2, 0, 1, 0);

        // R8: pulse one cycle short of the hold time
        async_t2 = 0; gie = 1; sut_sel = 0; evt_en = 0;
        go_sleep(0);
        ext_en = 2'b01; ext_lvl = 2'b01;
        repeat (HOLD - 1) @(negedge clk);
        ext_lvl = 0;
        wait_wake(12, k);
        chk("R8", "short level pulse ignored", k, 0);
        chk("R8", "clock still gated after short pulse", cpu_clk_en, 0);
        ext_lvl = 2'b01;
        wait_wake(12, k);
        chk("R8", "full level hold wakes", k, HOLD + 1);
        ext_lvl = 0; ext_en = 0;
        repeat (2) @(negedge clk);

        done = 1;
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end

endmodule